// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Controller

This block serves byte reads from a simple memory-mapped request port by running SPI flash read transactions. Every access follows one programmable read template held in a single 32-bit configuration word: the opcode, the lane width used after the opcode, the number of dummy clocks, the address length and the largest burst allowed. The requester gives a byte address and a length of 1 to 16 bytes. The controller returns the bytes one per response beat, in ascending address order, and flags the last beat.

The upper address bits choose one of up to four flash devices. Each device owns a window of 2^WIN_LOG2 bytes, which is 128 MB by default. The bits below them form the offset that is sent to the flash. The serial side works in SPI mode 0: the clock idles low, the controller sends on the falling edge and samples on the rising edge. The opcode always goes out on lane 0. In dual or quad mode the address, dummy and data phases use the wide lanes. The serial clock half-period is a fixed number of system clocks, set by SCK_DIV.

Software can freeze the template with a lock bit. Each request takes a copy of the template when it is accepted, so a write to the configuration word during a transfer only applies to later requests.

Top module: `spi_flash_rd_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x0300_0003, all chip selects are high, the serial clock is low, every lane enable is 0 and the request port is ready.
- R2: The configuration word is laid out as follows: opcode in [7:0], lane mode in [9:8], dummy count in [13:12], address length in [17:16], burst code in [25:24] and lock in [31]. All other bits read back as zero.
- R3: Once bit 31 is set, later writes leave the configuration word unchanged until the next reset.
- R4: During a transfer only the chip select whose index equals address bits [WIN_LOG2+1:WIN_LOG2] is low, and never more than one is low.
- R5: The opcode is sent first, MSB first, over 8 clocks on lane 0, with only lane 0 enabled. This holds in every lane mode.
- R6: The address goes out MSB first. When bit 16 is 0 it is the low 24 offset bits; when bit 16 is 1 it is the offset zero-extended to 32 bits. Bit 17 is ignored. It uses lane 0 for mode 0 or 3, lanes 1:0 for mode 1 and lanes 3:0 for mode 2, and only those lanes are enabled.
- R7: When the dummy count N is not zero, 4*N dummy clocks follow the address, and no lane is driven during them.
- R8: Data is sampled on rising clock edges, MSB first, from lane 1 in single mode, lanes 1:0 in dual mode (lane 1 carries the higher bit) and lanes 3:0 in quad mode. Bytes are returned in ascending address order, and the response last flag is set only on the final byte.
- R9: The number of bytes returned is the smaller of (length field + 1) and 2^(burst code + 1).
- R10: Between transfers, all chip selects stay high for at least 2*SCK_DIV system clocks. The serial clock is low whenever all chip selects are high. The request port is ready only while no device is selected.
- R11: A transfer uses the template that was in force when its request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration word readback |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | ADDR_W | Byte address: device index over window offset |
| req_len_i | input | 4 | Requested byte count minus one |
| rsp_valid_o | output | 1 | One returned byte is valid |
| rsp_data_o | output | 8 | Returned byte |
| rsp_last_o | output | 1 | Final byte of the transfer |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_no | output | NUM_CS | Active-low device selects |
| spi_io_o | output | 4 | Lane output values |
| spi_io_oe_o | output | 4 | Lane output enables |
| spi_io_i | input | 4 | Lane input values |

## Verification
The bench builds the block with NUM_CS=4, WIN_LOG2=27 and SCK_DIV=2. With these values all four devices and the top offsets of each 128 MB window can be reached. The even divider also makes the minimum deselect gap a real bound of four system clocks. A behavioural flash model in the bench decodes the opcode and address lane by lane, counts the dummy clocks and drives data bytes computed from the device index and the address. If any phase is misaligned, the returned bytes do not match. Random templates cover all four lane modes, every dummy count, both address lengths and every burst cap. Directed cases cover the reserved mode, the ignored address-length bit, full 16-byte bursts at the end of a window, a cap shorter than the request, a reconfiguration during a transfer and the lock.

// File: rtl/spi_frd_pkg.sv
package spi_frd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_GAP
  } seq_state_e;

  // decoded read template
  typedef struct packed {
    logic [7:0] opcode;
    logic [1:0] lane_log;   // 0: x1, 1: x2, 2: x4
    logic [1:0] dummy;      // dummy clocks / 4
    logic       four_byte;
    logic [1:0] burst;      // cap = 2 << burst
  } rd_tmpl_t;

  localparam logic [31:0] CFG_MASK  = 32'h8303_33FF;
  localparam logic [31:0] CFG_RESET = 32'h0300_0003;
  localparam int          CFG_LOCK  = 31;

  function automatic rd_tmpl_t decode_cfg(input logic [31:0] w);
    rd_tmpl_t t;
    t.opcode    = w[7:0];
    t.lane_log  = (w[9:8] == 2'd3) ? 2'd0 : w[9:8];  // reserved mode runs as x1
    t.dummy     = w[13:12];
    t.four_byte = w[16];
    t.burst     = w[25:24];
    return t;
  endfunction

endpackage

// File: rtl/spi_frd_cfg.sv
module spi_frd_cfg
  import spi_frd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] cfg_o,
  output rd_tmpl_t    tmpl_o
);

  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cfg_q <= CFG_RESET;
    else if (we_i && !cfg_q[CFG_LOCK])  cfg_q <= wdata_i & CFG_MASK;
  end

  assign cfg_o  = cfg_q;
  assign tmpl_o = decode_cfg(cfg_q);

  a_r3_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_q[CFG_LOCK]) |-> $stable(cfg_q));

endmodule

// File: rtl/spi_frd_tick.sv
module spi_frd_tick #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_frd_seq.sv
module spi_frd_seq
  import spi_frd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int OFF_W  = 27,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  rd_tmpl_t          tmpl_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [3:0]        req_len_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_data_o,
  output logic              rsp_last_o,
  output logic              sck_o,
  output logic [NUM_CS-1:0] cs_no,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i
);

  seq_state_e  state_q;
  rd_tmpl_t    t_q;
  logic        sck_q;
  logic [NUM_CS-1:0] cs_q;
  logic [31:0] tx_q;
  logic [31:0] off_q;
  logic [7:0]  clk_left_q;
  logic [7:0]  rx_q;
  logic [2:0]  bitc_q;
  logic [4:0]  len_q;
  logic [4:0]  bytes_left_q;
  logic        gap_q;
  logic        rsp_valid_q, rsp_last_q;
  logic [7:0]  rsp_data_q;

  // request side decode
  logic [NUM_CS-1:0] sel;
  logic [4:0]        req_bytes, req_cap, eff_len;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) sel[i] = (req_cs_i == CS_W'(i));
    req_bytes = {1'b0, req_len_i} + 5'd1;
    req_cap   = 5'd2 << tmpl_i.burst;
    eff_len   = (req_bytes < req_cap) ? req_bytes : req_cap;
  end

  // per-template phase lengths
  logic [2:0] cpb_m1;
  logic [7:0] addr_clks, data_clks;
  logic [2:0] shamt;
  logic [7:0] rx_next;

  always_comb begin
    unique case (t_q.lane_log)
      2'd1: begin
        cpb_m1    = 3'd3;
        addr_clks = t_q.four_byte ? 8'd16 : 8'd12;
        data_clks = {1'b0, len_q, 2'b00};
        rx_next   = {rx_q[5:0], io_i[1:0]};
      end
      2'd2: begin
        cpb_m1    = 3'd1;
        addr_clks = t_q.four_byte ? 8'd8 : 8'd6;
        data_clks = {2'b00, len_q, 1'b0};
        rx_next   = {rx_q[3:0], io_i};
      end
      default: begin
        cpb_m1    = 3'd7;
        addr_clks = t_q.four_byte ? 8'd32 : 8'd24;
        data_clks = {len_q, 3'b000};
        rx_next   = {rx_q[6:0], io_i[1]};
      end
    endcase
    shamt = (state_q == ST_CMD) ? 3'd1 : (3'd1 << t_q.lane_log);
  end

  logic active, rise, fall;
  assign active = state_q inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA};
  assign rise   = tick_i && active && !sck_q;
  assign fall   = tick_i && active && sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      t_q          <= '0;
      sck_q        <= 1'b0;
      cs_q         <= '1;
      tx_q         <= '0;
      off_q        <= '0;
      clk_left_q   <= '0;
      rx_q         <= '0;
      bitc_q       <= '0;
      len_q        <= '0;
      bytes_left_q <= '0;
      gap_q        <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_last_q   <= 1'b0;
      rsp_data_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          t_q          <= tmpl_i;           // template snapshot
          off_q        <= 32'(req_off_i);
          len_q        <= eff_len;
          bytes_left_q <= eff_len;
          cs_q         <= ~sel;
          tx_q         <= {tmpl_i.opcode, 24'h0};
          clk_left_q   <= 8'd8;
          bitc_q       <= '0;
          state_q      <= ST_CMD;
        end
        ST_GAP: if (tick_i) begin
          if (gap_q) state_q <= ST_IDLE;
          gap_q <= 1'b1;
        end
        default: begin
          if (rise) begin
            sck_q <= 1'b1;
            if (state_q == ST_DATA) begin
              rx_q <= rx_next;
              if (bitc_q == cpb_m1) begin
                bitc_q       <= '0;
                rsp_valid_q  <= 1'b1;
                rsp_data_q   <= rx_next;
                rsp_last_q   <= (bytes_left_q == 5'd1);
                bytes_left_q <= bytes_left_q - 5'd1;
              end else begin
                bitc_q <= bitc_q + 3'd1;
              end
            end
          end else if (fall) begin
            sck_q <= 1'b0;
            if (clk_left_q == 8'd1) begin
              unique case (state_q)
                ST_CMD: begin
                  tx_q       <= t_q.four_byte ? off_q : {off_q[23:0], 8'h0};
                  clk_left_q <= addr_clks;
                  state_q    <= ST_ADDR;
                end
                ST_ADDR: begin
                  if (t_q.dummy != 2'd0) begin
                    clk_left_q <= {4'd0, t_q.dummy, 2'b00};
                    state_q    <= ST_DUMMY;
                  end else begin
                    clk_left_q <= data_clks;
                    state_q    <= ST_DATA;
                  end
                end
                ST_DUMMY: begin
                  clk_left_q <= data_clks;
                  state_q    <= ST_DATA;
                end
                default: begin
                  cs_q    <= '1;
                  gap_q   <= 1'b0;
                  state_q <= ST_GAP;
                end
              endcase
            end else begin
              clk_left_q <= clk_left_q - 8'd1;
              tx_q       <= tx_q << shamt;
            end
          end
        end
      endcase
    end
  end

  // lane drive
  always_comb begin
    io_o    = '0;
    io_oe_o = '0;
    if (state_q == ST_CMD) begin
      io_o[0]    = tx_q[31];
      io_oe_o[0] = 1'b1;
    end else if (state_q == ST_ADDR) begin
      unique case (t_q.lane_log)
        2'd1:    begin io_o[1:0] = tx_q[31:30]; io_oe_o = 4'b0011; end
        2'd2:    begin io_o      = tx_q[31:28]; io_oe_o = 4'b1111; end
        default: begin io_o[0]   = tx_q[31];    io_oe_o = 4'b0001; end
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign sck_o       = sck_q;
  assign cs_no       = cs_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_last_o  = rsp_last_q;

  a_r4_single_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_q) <= 1);
  a_r10_sck_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_q) |-> !sck_q);
  a_r10_ready_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (&cs_q));
  a_r8_rsp_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_q |-> ($past(state_q) == ST_DATA));
  a_r9_within_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_q |-> ($past(bytes_left_q) != 5'd0));

endmodule

// File: rtl/spi_flash_rd_ctrl.sv
module spi_flash_rd_ctrl
  import spi_frd_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int WIN_LOG2 = 27,
  parameter int SCK_DIV  = 2,
  parameter int ADDR_W   = WIN_LOG2 + ((NUM_CS > 1) ? $clog2(NUM_CS) : 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_len_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_data_o,
  output logic              rsp_last_o,
  output logic              spi_sck_o,
  output logic [NUM_CS-1:0] spi_cs_no,
  output logic [3:0]        spi_io_o,
  output logic [3:0]        spi_io_oe_o,
  input  logic [3:0]        spi_io_i
);

  localparam int CS_W = ADDR_W - WIN_LOG2;

  rd_tmpl_t tmpl;
  logic     tick;

  spi_frd_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_rdata_o),
    .tmpl_o  (tmpl)
  );

  spi_frd_tick #(.DIV(SCK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  spi_frd_seq #(
    .NUM_CS (NUM_CS),
    .OFF_W  (WIN_LOG2),
    .CS_W   (CS_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .tmpl_i      (tmpl),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_cs_i    (req_addr_i[ADDR_W-1:WIN_LOG2]),
    .req_off_i   (req_addr_i[WIN_LOG2-1:0]),
    .req_len_i   (req_len_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_last_o  (rsp_last_o),
    .sck_o       (spi_sck_o),
    .cs_no       (spi_cs_no),
    .io_o        (spi_io_o),
    .io_oe_o     (spi_io_oe_o),
    .io_i        (spi_io_i)
  );

endmodule

// File: tb/spi_flash_rd_ctrl_test.sv
`timescale 1ns/1ps
module spi_flash_rd_ctrl_test;

  localparam int SCK_DIV = 2;
  localparam logic [31:0] MASK = 32'h8303_33FF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [28:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        rsp_valid, rsp_last;
  logic [7:0]  rsp_data;
  logic        sck;
  logic [3:0]  cs_n, io_o, io_oe;
  logic [3:0]  io_in = '0;

  always #2 clk = ~clk;  // 250 MHz

  spi_flash_rd_ctrl #(.NUM_CS(4), .WIN_LOG2(27), .SCK_DIV(SCK_DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_io_o(io_o), .spi_io_oe_o(io_oe),
    .spi_io_i(io_in)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flash_byte(input int chip, input int unsigned off);
    int unsigned v;
    v = (off * 29) ^ (off >> 7) ^ (chip * 91) ^ 32'hA7;
    return v[7:0];
  endfunction

  // flash model state
  int          s_lanes = 1, s_ab = 3, s_dum = 0, s_len = 0, s_chip = 0;
  int unsigned s_off = 0;
  logic [3:0]  s_cs = 4'hF;
  int          rise_n = 0;
  logic [7:0]  op_rx;
  logic [31:0] addr_rx;
  bit          oe_err_cmd, oe_err_addr, oe_err_dum, cs_err;

  function automatic logic [3:0] lane_mask(input int n);
    return (n == 4) ? 4'hF : (n == 2) ? 4'h3 : 4'h1;
  endfunction

  always @(posedge sck) begin
    int a_clks;
    rise_n++;
    a_clks = s_ab * 8 / s_lanes;
    if (cs_n !== s_cs) cs_err = 1;
    if (rise_n <= 8) begin
      op_rx = {op_rx[6:0], io_o[0]};
      if (io_oe !== 4'h1) oe_err_cmd = 1;
    end else if (rise_n <= 8 + a_clks) begin
      addr_rx = (addr_rx << s_lanes) | 32'(io_o & lane_mask(s_lanes));
      if (io_oe !== lane_mask(s_lanes)) oe_err_addr = 1;
    end else begin
      if (io_oe !== 4'h0) oe_err_dum = 1;
    end
  end

  always @(negedge sck) begin
    int j, cpb;
    logic [7:0] b;
    logic [3:0] v;
    cpb = 8 / s_lanes;
    j = rise_n - (8 + s_ab * 8 / s_lanes + s_dum);
    io_in = 4'h0;
    if (j >= 0 && j < s_len * cpb) begin
      b = flash_byte(s_chip, s_off + 32'(j / cpb));
      v = 4'((b >> (8 - s_lanes * ((j % cpb) + 1))) & ((1 << s_lanes) - 1));
      if (s_lanes == 1) io_in[1] = v[0];
      else io_in = v;
    end
  end

  // response capture
  logic [7:0] rx_buf [32];
  bit         rx_lst [32];
  int         rx_n = 0;
  always @(negedge clk) begin
    if (rsp_valid && rx_n < 32) begin
      rx_buf[rx_n] = rsp_data;
      rx_lst[rx_n] = rsp_last;
      rx_n++;
    end
  end

  // deselect gap and idle clock monitor
  int hi_cnt = 0;
  bit sck_idle_err = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (&cs_n) begin
        hi_cnt++;
        if (sck) sck_idle_err = 1;
      end else begin
        if (hi_cnt > 0)
          chk(hi_cnt >= 2 * SCK_DIV, "R10", "deselect gap", hi_cnt, 2 * SCK_DIV);
        hi_cnt = 0;
      end
    end
  end

  logic [31:0] cur_cfg = 32'h0300_0003;

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
    if (!cur_cfg[31]) cur_cfg = w & MASK;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    cur_cfg = 32'h0300_0003;
    @(negedge clk);
    chk(cfg_rdata == 32'h0300_0003, "R1", "reset cfg", cfg_rdata, 32'h0300_0003);
    chk(cs_n == 4'hF, "R1", "reset cs", cs_n, 4'hF);
    chk(sck == 0 && io_oe == 0, "R1", "reset sck/oe", {sck, io_oe}, 0);
    chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
  endtask

  task automatic do_read(input int chip, input int unsigned off, input int lenf,
                         input bit mid_wr, input logic [31:0] new_cfg);
    int mode, cap, eff;
    logic [31:0] exp_addr;
    logic [31:0] used;
    used   = cur_cfg;
    mode   = int'(used[9:8]);
    s_lanes = (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
    s_ab   = used[16] ? 4 : 3;
    s_dum  = 4 * int'(used[13:12]);
    cap    = 2 << used[25:24];
    eff    = (lenf + 1 < cap) ? lenf + 1 : cap;
    s_len  = eff; s_chip = chip; s_off = off;
    s_cs   = ~(4'b0001 << chip);
    rise_n = 0; op_rx = 0; addr_rx = 0; rx_n = 0;
    oe_err_cmd = 0; oe_err_addr = 0; oe_err_dum = 0; cs_err = 0;
    exp_addr = (s_ab == 3) ? (off & 32'hFF_FFFF) : off;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1;
    req_addr  = {2'(chip), 27'(off)};
    req_len   = 4'(lenf);
    @(negedge clk);
    req_valid = 0;
    if (mid_wr) begin
      repeat (3) @(negedge clk);
      write_cfg(new_cfg);
    end
    while (!req_ready) @(negedge clk);
    chk(op_rx == used[7:0], "R5", "opcode", op_rx, used[7:0]);
    chk(!oe_err_cmd, "R5", "opcode lane enable", oe_err_cmd, 0);
    chk(addr_rx == exp_addr, "R6", "address", addr_rx, exp_addr);
    chk(!oe_err_addr, "R6", "address lane enable", oe_err_addr, 0);
    chk(!oe_err_dum, "R7", "dummy/data lanes undriven", oe_err_dum, 0);
    chk(!cs_err, "R4", "chip select", cs_err, 0);
    chk(rx_n == eff, "R9", "byte count", rx_n, eff);
    for (int i = 0; i < eff && i < rx_n; i++) begin
      chk(rx_buf[i] == flash_byte(chip, off + 32'(i)), "R8", "data byte",
          rx_buf[i], flash_byte(chip, off + 32'(i)));
      chk(rx_lst[i] == (i == eff - 1), "R8", "last flag", rx_lst[i], i == eff - 1);
    end
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    do_reset();

    // R2: field layout, undefined bits dropped; mode 3 runs single lane (R6)
    write_cfg(32'h7FFF_FFFF);
    chk(cfg_rdata == 32'h0303_33FF, "R2", "masked cfg", cfg_rdata, 32'h0303_33FF);
    do_read(2, 27'h000_0100, 3, 0, 0);

    // default template, single lane 3-byte
    write_cfg(32'h0300_0003);
    do_read(0, 27'h012_3456, 3, 0, 0);

    // quad, 4-byte, 8 dummy clocks, full burst at window top
    write_cfg(32'h0301_22EB);
    chk(cfg_rdata == 32'h0301_22EB, "R2", "quad cfg", cfg_rdata, 32'h0301_22EB);
    do_read(3, 27'h7FF_FFF0, 15, 0, 0);

    // dual, no dummy, cap of 2 bytes below request (R9)
    write_cfg(32'h0000_013B);
    do_read(1, 27'h055_AA55, 9, 0, 0);

    // R6: bit 17 ignored, still 3-byte
    write_cfg(32'h0202_106B);
    do_read(1, 27'h7AB_CDEF, 7, 0, 0);

    // R11: reconfiguration during a transfer applies to the next one
    write_cfg(32'h0300_0003);
    do_read(2, 27'h000_0040, 4, 1, 32'h0301_12BB);
    chk(cfg_rdata == 32'h0301_12BB, "R11", "new cfg stored", cfg_rdata, 32'h0301_12BB);
    do_read(2, 27'h000_0040, 4, 0, 0);

    // random templates and requests, back to back
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w;
      w = $urandom;
      w[31] = 1'b0;
      write_cfg(w);
      chk(cfg_rdata == (w & MASK), "R2", "random cfg", cfg_rdata, w & MASK);
      do_read(int'($urandom_range(3, 0)), $urandom & 32'h7FF_FFFF,
              int'($urandom_range(15, 0)), 0, 0);
    end

    chk(!sck_idle_err, "R10", "clock low while deselected", sck_idle_err, 0);

    // R3: lock
    write_cfg(32'h8300_10BB);
    chk(cfg_rdata == 32'h8300_10BB, "R3", "lock write", cfg_rdata, 32'h8300_10BB);
    write_cfg(32'h0000_0003);
    chk(cfg_rdata == 32'h8300_10BB, "R3", "write ignored when locked", cfg_rdata, 32'h8300_10BB);
    do_read(0, 27'h000_1234, 5, 0, 0);

    do_reset();
    write_cfg(32'h0000_0013);
    chk(cfg_rdata == 32'h0000_0013, "R3", "unlocked after reset", cfg_rdata, 32'h0000_0013);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule